// File: doc/BRIEF.md
# Commit Token Arbiter with Write-Set Broadcast

This unit serialises transaction commits in a multi-core system that keeps speculative results private until commit and lets the committing core win every conflict. A core that reaches the end of a transaction raises a request. The arbiter hands a single commit token to exactly one core at a time, so commits form one global order.

The token holder then streams the addresses of its write-set into the arbiter, one address per cycle, and flags the final address. Each other active core keeps a small tag array of the addresses it has read. Every streamed address is compared against all of these arrays in the same cycle. A core whose array holds the address is aborted. The holder is never stalled and never aborted, so at least one transaction always completes.

An aborted core loses its read-set and any request it was still waiting on. Writing data back to memory is handled elsewhere.

Top module: `commit_token_arb`

## Requirements
- R1: At most one bit of `commit_gnt` is set at any time. When the token is free, a `commit_req` pulse from an active core gives that core the grant two cycles later.
- R2: Grants rotate round-robin. The search starts at the core after the one last granted, wraps from the highest index to core 0, and core 0 is searched first after reset.
- R3: The grant holds through every broadcast beat that is not flagged last. It drops at the clock edge that samples the beat with `ws_last` set. The earliest next grant appears one cycle after that.
- R4: During a grant, a beat (`ws_valid`) makes `abort` pulse for one cycle, on the following cycle, for every active non-holder core whose read-set holds `ws_addr`. Several cores may abort on the same beat.
- R5: The token holder is never aborted, even when its own read-set holds the broadcast address.
- R6: A core whose read-set lacks the address is not aborted. A beat presented while no core holds the token is ignored.
- R7: If a core is aborted while its request is pending, the request is withdrawn and the core is never granted for it.
- R8: `tx_begin` marks a core active and empties its read-set, so addresses read before it no longer cause an abort.
- R9: Each read-set holds `RS_DEPTH` distinct addresses. A new address recorded when the set is full makes that core conflict with every later broadcast address until its next `tx_begin` or abort.
- R10: After reset no grant and no abort are asserted, and all cores are inactive.
- R11: A `commit_req` from an inactive core is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_begin | input | NCORE | Per-core start of a transaction |
| rd_valid | input | NCORE | Per-core transactional read to record |
| rd_addr | input | NCORE*ADDR_W | Per-core read address, core i at bits [i*ADDR_W +: ADDR_W] |
| commit_req | input | NCORE | Per-core commit request pulse |
| commit_gnt | output | NCORE | One-hot commit token grant |
| ws_valid | input | 1 | Write-set address beat from the holder |
| ws_addr | input | ADDR_W | Broadcast write-set address |
| ws_last | input | 1 | Marks the final write-set beat |
| abort | output | NCORE | Per-core abort pulse |

## Verification
The bench builds the block with four cores, 8-bit addresses and a read-set depth of two. The small depth lets a third distinct read overflow a read-set, which exercises the conservative conflict path. Four cores give enough requesters to show the round-robin pointer wrapping past the highest index. They also allow one holder, one waiting core and one unrelated core to be active at the same time, so the withdrawal of a pending request and multi-core aborts on a single beat can both be observed.

// File: rtl/ctarb_pkg.sv
package ctarb_pkg;
    typedef enum logic {
        TOK_IDLE = 1'b0,
        TOK_HELD = 1'b1
    } tok_state_e;
endpackage

// File: rtl/ctarb_rr_pick.sv
module ctarb_rr_pick #(
    parameter int NCORE = 4,
    localparam int IDX_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic [NCORE-1:0] req,
    input  logic [IDX_W-1:0] ptr,
    output logic [NCORE-1:0] pick,
    output logic             any
);
    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int k = 0; k < NCORE; k++) begin
            int idx;
            idx = (int'(ptr) + k) % NCORE;
            if (!any && req[idx]) begin
                pick[idx] = 1'b1;
                any       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ctarb_readset.sv
module ctarb_readset #(
    parameter int ADDR_W   = 16,
    parameter int RS_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rec_valid,
    input  logic [ADDR_W-1:0] rec_addr,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              hit
);
    typedef struct packed {
        logic [RS_DEPTH-1:0][ADDR_W-1:0] tag;
        logic [RS_DEPTH-1:0]             vld;
        logic                            sat;
    } rs_t;

    rs_t rs_d, rs_q;

    always_comb begin
        logic present;
        logic placed;
        rs_d    = rs_q;
        present = 1'b0;
        placed  = 1'b0;
        hit     = rs_q.sat;
        for (int i = 0; i < RS_DEPTH; i++) begin
            if (rs_q.vld[i] && rs_q.tag[i] == rec_addr)   present = 1'b1;
            if (rs_q.vld[i] && rs_q.tag[i] == probe_addr) hit     = 1'b1;
        end
        if (clr) begin
            rs_d = '0;
        end else if (rec_valid && !present && !rs_q.sat) begin
            for (int i = 0; i < RS_DEPTH; i++) begin
                if (!placed && !rs_q.vld[i]) begin
                    rs_d.tag[i] = rec_addr;
                    rs_d.vld[i] = 1'b1;
                    placed      = 1'b1;
                end
            end
            if (!placed) rs_d.sat = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end
endmodule

// File: rtl/commit_token_arb.sv
module commit_token_arb
    import ctarb_pkg::*;
#(
    parameter int NCORE    = 4,
    parameter int ADDR_W   = 16,
    parameter int RS_DEPTH = 4,
    localparam int IDX_W   = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCORE-1:0]        tx_begin,
    input  logic [NCORE-1:0]        rd_valid,
    input  logic [NCORE*ADDR_W-1:0] rd_addr,
    input  logic [NCORE-1:0]        commit_req,
    output logic [NCORE-1:0]        commit_gnt,
    input  logic                    ws_valid,
    input  logic [ADDR_W-1:0]       ws_addr,
    input  logic                    ws_last,
    output logic [NCORE-1:0]        abort
);
    typedef struct packed {
        tok_state_e       tok;
        logic [NCORE-1:0] active;
        logic [NCORE-1:0] pend;
        logic [NCORE-1:0] gnt;
        logic [NCORE-1:0] abort;
        logic [IDX_W-1:0] ptr;
    } arb_t;

    arb_t             st_d, st_q;
    logic [NCORE-1:0] rs_hit;
    logic [NCORE-1:0] rs_clr;
    logic [NCORE-1:0] rs_rec;
    logic [NCORE-1:0] abort_dec;
    logic [NCORE-1:0] pick;
    logic             pick_any;

    ctarb_rr_pick #(.NCORE(NCORE)) u_pick (
        .req  (st_q.pend),
        .ptr  (st_q.ptr),
        .pick (pick),
        .any  (pick_any)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        ctarb_readset #(.ADDR_W(ADDR_W), .RS_DEPTH(RS_DEPTH)) u_rs (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (rs_clr[c]),
            .rec_valid  (rs_rec[c]),
            .rec_addr   (rd_addr[c*ADDR_W +: ADDR_W]),
            .probe_addr (ws_addr),
            .hit        (rs_hit[c])
        );
    end

    assign rs_clr = tx_begin | abort_dec;
    assign rs_rec = rd_valid & st_q.active;

    always_comb begin
        logic beat;
        st_d      = st_q;
        st_d.abort = '0;
        beat      = (st_q.tok == TOK_HELD) && ws_valid;
        for (int i = 0; i < NCORE; i++) begin
            abort_dec[i] = beat && st_q.active[i] && !st_q.gnt[i] && rs_hit[i];
            if (abort_dec[i]) begin
                st_d.active[i] = 1'b0;
                st_d.pend[i]   = 1'b0;
                st_d.abort[i]  = 1'b1;
            end
            if (tx_begin[i] && !st_q.gnt[i]) begin
                st_d.active[i] = 1'b1;
                st_d.pend[i]   = 1'b0;
            end else if (commit_req[i] && st_q.active[i] && !st_q.gnt[i] && !abort_dec[i]) begin
                st_d.pend[i] = 1'b1;
            end
        end
        if (beat && ws_last) begin
            st_d.tok    = TOK_IDLE;
            st_d.active = st_d.active & ~st_q.gnt;
            st_d.gnt    = '0;
        end else if (st_q.tok == TOK_IDLE && pick_any) begin
            st_d.tok  = TOK_HELD;
            st_d.gnt  = pick;
            st_d.pend = st_d.pend & ~pick;
            for (int i = 0; i < NCORE; i++) begin
                if (pick[i]) st_d.ptr = IDX_W'((i + 1) % NCORE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.tok <= TOK_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_gnt = st_q.gnt;
    assign abort      = st_q.abort;
endmodule

// File: rtl/commit_token_arb_chk.sv
module commit_token_arb_chk #(
    parameter int NCORE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCORE-1:0] commit_gnt,
    input logic             ws_valid,
    input logic             ws_last,
    input logic [NCORE-1:0] abort
);
    // R1
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit_gnt));

    // R3
    gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|commit_gnt && !(ws_valid && ws_last)) |=> $stable(commit_gnt));

    // R3
    gnt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|commit_gnt && ws_valid && ws_last) |=> (commit_gnt == '0));

    // R5
    holder_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|abort) |-> ((abort & $past(commit_gnt)) == '0));

    // R4
    abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|abort) |-> $past(ws_valid && (|commit_gnt)));
endmodule

bind commit_token_arb commit_token_arb_chk #(.NCORE(NCORE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_gnt (commit_gnt),
    .ws_valid   (ws_valid),
    .ws_last    (ws_last),
    .abort      (abort)
);

// File: tb/commit_token_arb_bench.sv
`timescale 1ns/1ps
module commit_token_arb_bench;
    localparam int N  = 4;
    localparam int AW = 8;
    localparam int RD = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  tx_begin = '0, rd_valid = '0, commit_req = '0;
    logic [N*AW-1:0] rd_addr = '0;
    logic [N-1:0]  commit_gnt, abort;
    logic          ws_valid = 1'b0, ws_last = 1'b0;
    logic [AW-1:0] ws_addr = '0;
    int            n_run = 0, n_fail = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    commit_token_arb #(.NCORE(N), .ADDR_W(AW), .RS_DEPTH(RD)) u_commit_token_arb (
        .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .rd_valid(rd_valid),
        .rd_addr(rd_addr), .commit_req(commit_req), .commit_gnt(commit_gnt),
        .ws_valid(ws_valid), .ws_addr(ws_addr), .ws_last(ws_last), .abort(abort)
    );

    typedef struct packed {
        logic [1:0]    rdr;
        logic [AW-1:0] ra;
        logic [AW-1:0] ba;
        logic          ab;
    } vec_t;
    // holder is always core 3
    localparam vec_t VEC [6] = '{
        '{2'd1, 8'h10, 8'h10, 1'b1},
        '{2'd2, 8'h21, 8'h22, 1'b0},
        '{2'd1, 8'h33, 8'h33, 1'b1},
        '{2'd2, 8'h44, 8'h44, 1'b1},
        '{2'd3, 8'h55, 8'h55, 1'b0},
        '{2'd0, 8'h66, 8'h67, 1'b0}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic begin_tx(logic [N-1:0] m);
        tx_begin = m; tick(); tx_begin = '0;
    endtask

    task automatic rec(int c, logic [AW-1:0] a);
        rd_valid[c] = 1'b1; rd_addr[c*AW +: AW] = a; tick(); rd_valid = '0;
    endtask

    task automatic req(logic [N-1:0] m);
        commit_req = m; tick(); commit_req = '0;
    endtask

    task automatic beat(logic [AW-1:0] a, logic last);
        ws_valid = 1'b1; ws_addr = a; ws_last = last; tick();
        ws_valid = 1'b0; ws_last = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        check("R10 reset gnt", 32'(commit_gnt), 0);
        check("R10 reset abort", 32'(abort), 0);
        rst_n = 1'b1;
        tick();

        foreach (VEC[v]) begin
            begin_tx(4'b1000 | (4'b0001 << VEC[v].rdr));
            rec(int'(VEC[v].rdr), VEC[v].ra);
            req(4'b1000);
            check("R1 no grant yet", 32'(commit_gnt), 0);
            tick();
            check("R1 grant core3", 32'(commit_gnt), 32'h8);
            beat(VEC[v].ba, 1'b1);
            check("R4/R5/R6 vector abort", 32'(abort),
                  VEC[v].ab ? (32'h1 << VEC[v].rdr) : 0);
            check("R3 release", 32'(commit_gnt), 0);
            tick();
        end

        // R2 rotation: last grant core 3, so core 0 first
        begin_tx(4'b0111);
        req(4'b0111); tick();
        check("R2 first pick", 32'(commit_gnt), 32'h1);
        beat(8'hF0, 1'b1);
        check("R6 empty sets no abort", 32'(abort), 0);
        tick();
        check("R2 next pick", 32'(commit_gnt), 32'h2);
        beat(8'hF1, 1'b0);
        check("R3 hold mid stream", 32'(commit_gnt), 32'h2);
        beat(8'hF2, 1'b1);
        check("R3 release after last", 32'(commit_gnt), 0);
        tick();
        check("R2 third pick", 32'(commit_gnt), 32'h4);
        beat(8'hF3, 1'b1);
        // R2 wrap: pointer at 3, cores 0 and 2 request
        begin_tx(4'b0101);
        req(4'b0101); tick();
        check("R2 wrap to core0", 32'(commit_gnt), 32'h1);
        beat(8'hF4, 1'b1); tick();
        check("R2 then core2", 32'(commit_gnt), 32'h4);
        beat(8'hF5, 1'b1); tick();

        // R4 two cores abort on one beat
        begin_tx(4'b0111);
        rec(0, 8'hB0); rec(1, 8'hB0);
        req(4'b0100); tick();
        beat(8'hB0, 1'b1);
        check("R4 multi abort", 32'(abort), 32'h3);
        tick();

        // R7 pending request withdrawn on abort
        begin_tx(4'b0111);
        rec(0, 8'h70);
        req(4'b0100); tick();
        check("R7 holder core2", 32'(commit_gnt), 32'h4);
        req(4'b0001);
        beat(8'h70, 1'b0);
        check("R7 waiting core aborted", 32'(abort), 32'h1);
        beat(8'h71, 1'b1);
        tick();
        check("R7 no grant after withdraw", 32'(commit_gnt), 0);
        tick();
        check("R7 still no grant", 32'(commit_gnt), 0);

        // R11 inactive core request ignored (core 3 inactive)
        req(4'b1000); tick();
        check("R11 inactive ignored", 32'(commit_gnt), 0);

        // R6 beat with no holder ignored
        begin_tx(4'b0010);
        rec(1, 8'h80);
        beat(8'h80, 1'b1);
        check("R6 no holder no abort", 32'(abort), 0);

        // R8 restart clears read-set
        begin_tx(4'b0010);
        rec(1, 8'h90);
        begin_tx(4'b0110);
        req(4'b0100); tick();
        beat(8'h90, 1'b1);
        check("R8 cleared set no abort", 32'(abort), 0);
        tick();

        // R9 overflow of read-set
        begin_tx(4'b0110);
        rec(1, 8'hA1); rec(1, 8'hA2); rec(1, 8'hA3);
        req(4'b0100); tick();
        beat(8'hEE, 1'b1);
        check("R9 overflow conservative abort", 32'(abort), 32'h2);
        tick();
        check("R4 abort is one pulse", 32'(abort), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule